// File: doc/BRIEF.md
# Privileged Register Access Guard

This block stands on the bus side of a peripheral register file and decides, for every request, whether it may go through. Each request carries a byte address, a read/write flag, a command code and a privilege flag. An allowed access to the register window is passed straight to the register file. An access to a guard-owned register (the protection control word or a small read-only identification region) is served locally. A refused access gets an error response and touches nothing.

Two rules govern privilege. The protection control word can only ever be reached from privileged mode. Setting its enable bit extends the same restriction to every address. Only two classes of fault raise the error flag: privilege violations and unsupported command codes. Unmapped addresses and writes to read-only words complete quietly.

Every request gets a response exactly one clock later. The response is a valid strobe, a data word and one error flag.

Top module: `priv_access_guard`

## Requirements
- R1: After reset the protection word reads 0. A user-mode access to the register window completes without error.
- R2: A user-mode access of any kind to the protection word (byte address 0x4C) gets an error. The protection word is not changed, whatever its enable bit holds.
- R3: While protection bit 0 is 1, every user-mode request at any address gets an error.
- R4: Only command code 0 is supported. A request with codes 1, 2 or 3 gets an error even from privileged mode.
- R5: An address that decodes to nothing completes with no error and read data 0. This covers misaligned addresses, 0x08, 0x0C and everything above 0x4C. Nothing is forwarded.
- R6: A write to the read-only region (0x00 and 0x04) completes with no error and leaves its contents unchanged.
- R7: A rejected request is never forwarded, changes no state and returns data 0.
- R8: rspValid is high exactly in the cycle after a request cycle, and low otherwise. Write responses carry data 0.
- R9: An accepted write to the protection word stores write-data bit 0. Bits above bit 0 always read 0.
- R10: An accepted aligned access to 0x10 through 0x48 is forwarded in the same cycle, with the request's address, write flag and write data. For reads, the register file's read data is returned in the response.
- R11: Read-only word i (byte address 4*i) reads ROM_SEED + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCmd | input | 2 | Command code, only 0 supported |
| reqPriv | input | 1 | 1 = privileged, 0 = user |
| reqWdata | input | DATA_W | Write data |
| fwdValid | output | 1 | Access forwarded to register file |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdWrite | output | 1 | Forwarded write flag |
| fwdWdata | output | DATA_W | Forwarded write data |
| fwdRdata | input | DATA_W | Register file read data, same cycle |
| rspValid | output | 1 | Response strobe |
| rspRdata | output | DATA_W | Response read data |
| rspErr | output | 1 | Response error flag |

## Verification
The bench sweeps every byte address of a 7-bit space. Each address is tried with all four command codes, both privilege levels and both directions, once with protection off and once with it on. The sweep separates the error classes from the silent cases: a privilege fault, a bad code, an unmapped slot and a read-only write each land in a different part of the space. A stub register file in the bench tracks forwarded writes. Later reads then show that rejected, read-only and unmapped writes changed nothing, and that allowed writes landed with the right data.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;

  typedef enum logic [1:0] {
    CMD_SINGLE = 2'd0,
    CMD_RSVD1  = 2'd1,
    CMD_RSVD2  = 2'd2,
    CMD_RSVD3  = 2'd3
  } guardCmd_e;

  // Strobes from the decision logic to the datapath.
  typedef struct packed {
    logic valid;
    logic reject;
    logic isWrite;
    logic hitProt;
    logic hitRom;
    logic hitFwd;
    logic fwdGo;
    logic wrProt;
  } guardStrb_t;

endpackage

// File: rtl/priv_guard_ctrl.sv
module priv_guard_ctrl
  import priv_guard_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int PROT_ADDR = 'h4C,
  parameter int ROM_WORDS = 2,
  parameter int FWD_BASE  = 'h10,
  parameter int FWD_WORDS = 15,
  parameter int RIW       = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqCmd,
  input  logic              reqPriv,
  input  logic              protEn,
  output guardStrb_t        strb,
  output logic [RIW-1:0]    romIdx
);

  localparam logic [ADDR_W-1:0] PROT_A   = ADDR_W'(PROT_ADDR);
  localparam logic [ADDR_W-1:0] ROM_END  = ADDR_W'(4 * ROM_WORDS);
  localparam logic [ADDR_W-1:0] FWD_LO   = ADDR_W'(FWD_BASE);
  localparam logic [ADDR_W-1:0] FWD_HI   = ADDR_W'(FWD_BASE + 4 * (FWD_WORDS - 1));

  logic aligned, cmdOk, denyPriv;

  always_comb begin
    aligned        = (reqAddr[1:0] == 2'b00);
    cmdOk          = (guardCmd_e'(reqCmd) == CMD_SINGLE);
    strb.hitProt   = (reqAddr == PROT_A);
    strb.hitRom    = aligned && (reqAddr < ROM_END);
    strb.hitFwd    = aligned && (reqAddr >= FWD_LO) && (reqAddr <= FWD_HI);
    denyPriv       = !reqPriv && (strb.hitProt || protEn);
    strb.valid     = reqValid;
    strb.isWrite   = reqWrite;
    strb.reject    = reqValid && (!cmdOk || denyPriv);
    strb.fwdGo     = reqValid && !strb.reject && strb.hitFwd;
    strb.wrProt    = reqValid && !strb.reject && strb.hitProt && reqWrite;
    romIdx         = reqAddr[RIW+1:2];
  end

  assert_user_prot_rejected_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqPriv && reqAddr == PROT_A) |-> (strb.reject && !strb.wrProt));

  assert_lock_user_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqPriv && protEn) |-> strb.reject);

  assert_bad_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqCmd != 2'd0) |-> strb.reject);

  assert_reject_no_fwd_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.reject |-> (!strb.fwdGo && !strb.wrProt));

endmodule

// File: rtl/priv_guard_dp.sv
module priv_guard_dp
  import priv_guard_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROM_WORDS = 2,
  parameter int ROM_SEED  = 'h0A11_0000,
  parameter int RIW       = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrb_t        strb,
  input  logic [RIW-1:0]    romIdx,
  input  logic              protWrBit,
  input  logic [DATA_W-1:0] fwdRdata,
  output logic              protEn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  logic [DATA_W-1:0] romTab [ROM_WORDS];
  logic [DATA_W-1:0] readMux;

  for (genvar g = 0; g < ROM_WORDS; g++) begin : g_rom
    assign romTab[g] = DATA_W'(ROM_SEED + g);
  end

  always_comb begin
    readMux = '0;
    if (!strb.reject && !strb.isWrite) begin
      if (strb.hitProt)     readMux = DATA_W'(protEn);
      else if (strb.hitRom) readMux = romTab[romIdx];
      else if (strb.hitFwd) readMux = fwdRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protEn   <= 1'b0;
      rspValid <= 1'b0;
      rspRdata <= '0;
      rspErr   <= 1'b0;
    end else begin
      if (strb.wrProt) protEn <= protWrBit;
      rspValid <= strb.valid;
      rspErr   <= strb.reject;
      rspRdata <= strb.valid ? readMux : '0;
    end
  end

  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.valid |=> rspValid);

  assert_rsp_only_after_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.valid |=> !rspValid);

  assert_reject_zero_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == '0));

  assert_prot_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrProt |=> $stable(protEn));

endmodule

// File: rtl/priv_access_guard.sv
module priv_access_guard
  import priv_guard_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int PROT_ADDR = 'h4C,
  parameter int ROM_WORDS = 2,
  parameter int ROM_SEED  = 'h0A11_0000,
  parameter int FWD_BASE  = 'h10,
  parameter int FWD_WORDS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqCmd,
  input  logic              reqPriv,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              fwdWrite,
  output logic [DATA_W-1:0] fwdWdata,
  input  logic [DATA_W-1:0] fwdRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  localparam int RIW = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1;

  guardStrb_t     strb;
  logic [RIW-1:0] romIdx;
  logic           protEn;

  priv_guard_ctrl #(
    .ADDR_W(ADDR_W), .PROT_ADDR(PROT_ADDR), .ROM_WORDS(ROM_WORDS),
    .FWD_BASE(FWD_BASE), .FWD_WORDS(FWD_WORDS), .RIW(RIW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqCmd(reqCmd), .reqPriv(reqPriv),
    .protEn(protEn), .strb(strb), .romIdx(romIdx)
  );

  priv_guard_dp #(
    .DATA_W(DATA_W), .ROM_WORDS(ROM_WORDS), .ROM_SEED(ROM_SEED), .RIW(RIW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .romIdx(romIdx),
    .protWrBit(reqWdata[0]), .fwdRdata(fwdRdata), .protEn(protEn),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  assign fwdValid = strb.fwdGo;
  assign fwdAddr  = reqAddr;
  assign fwdWrite = reqWrite;
  assign fwdWdata = reqWdata;

endmodule

// File: tb/priv_access_guard_tb.sv
`timescale 1ns/1ps
module priv_access_guard_tb;

  localparam int SEED = 'h0A11_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [6:0]  reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqCmd = '0;
  logic        reqPriv = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        fwdValid, fwdWrite, rspValid, rspErr;
  logic [6:0]  fwdAddr;
  logic [31:0] fwdWdata, fwdRdata, rspRdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] stubRegs [15];
  logic [31:0] mdlRegs  [15];
  logic        protM;

  always #2 clk = ~clk;

  priv_access_guard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqCmd(reqCmd), .reqPriv(reqPriv), .reqWdata(reqWdata),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .fwdWrite(fwdWrite), .fwdWdata(fwdWdata),
    .fwdRdata(fwdRdata), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  // Stub register file behind the guard.
  always_comb begin
    if (fwdAddr >= 7'h10 && fwdAddr <= 7'h48) fwdRdata = stubRegs[(int'(fwdAddr) - 16) / 4];
    else fwdRdata = '0;
  end
  always @(posedge clk)
    if (fwdValid && fwdWrite) stubRegs[(int'(fwdAddr) - 16) / 4] <= fwdWdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (addr %h cmd %0d priv %0b wr %0b)",
               tag, act, exp, reqAddr, reqCmd, reqPriv, reqWrite);
    end
  endtask

  task automatic doReq(input logic [6:0] a, input logic [1:0] c, input logic p,
                       input logic w, input logic [31:0] d);
    logic isProt, isRom, isFwd, rej, expFwd;
    logic [31:0] expData;
    string tag;
    int idx;
    isProt = (a == 7'h4C);
    isRom  = (a[1:0] == 0) && (a < 7'h08);
    isFwd  = (a[1:0] == 0) && (a >= 7'h10) && (a <= 7'h48);
    rej    = (c != 0) || (!p && (isProt || protM));
    expFwd = !rej && isFwd;
    idx    = (int'(a) - 16) / 4;
    if (c != 0)               tag = "R4";
    else if (!p && isProt)    tag = "R2";
    else if (!p && protM)     tag = "R3";
    else if (isRom && w)      tag = "R6";
    else if (isRom)           tag = "R11";
    else if (isProt)          tag = "R9";
    else if (isFwd)           tag = "R10";
    else                      tag = "R5";
    expData = '0;
    if (!rej && !w) begin
      if (isProt)     expData = {31'd0, protM};
      else if (isRom) expData = SEED + a[2];
      else if (isFwd) expData = mdlRegs[idx];
    end
    @(negedge clk);
    chk("R8 idle", {31'd0, rspValid}, 32'd0);
    reqValid = 1'b1; reqAddr = a; reqCmd = c; reqPriv = p; reqWrite = w; reqWdata = d;
    #1;
    chk(rej ? "R7 fwd" : "R10 fwd", {31'd0, fwdValid}, {31'd0, expFwd});
    if (expFwd) begin
      chk("R10 addr", {25'd0, fwdAddr}, {25'd0, a});
      chk("R10 wr", {31'd0, fwdWrite}, {31'd0, w});
      chk("R10 wdata", fwdWdata, d);
    end
    @(negedge clk);
    chk("R8 rsp", {31'd0, rspValid}, 32'd1);
    chk(tag, {31'd0, rspErr}, {31'd0, rej});
    chk(rej ? "R7 data" : tag, rspRdata, expData);
    reqValid = 1'b0;
    if (!rej && w && isProt) protM = d[0];
    if (expFwd && w) mdlRegs[idx] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) begin
      stubRegs[i] = 32'h1111_0000 * (i + 1) + i;
      mdlRegs[i]  = 32'h1111_0000 * (i + 1) + i;
    end
    protM = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 rspValid", {31'd0, rspValid}, 32'd0);
    chk("R1 rspErr", {31'd0, rspErr}, 32'd0);
    doReq(7'h4C, 2'd0, 1'b1, 1'b0, 32'd0);  // R1 protection reads 0
    doReq(7'h10, 2'd0, 1'b0, 1'b0, 32'd0);  // R1 user access allowed
    doReq(7'h4C, 2'd0, 1'b1, 1'b1, 32'hFFFF_FFFE);  // R9 upper bits ignored
    doReq(7'h4C, 2'd0, 1'b1, 1'b0, 32'd0);
    for (int pv = 0; pv < 2; pv++) begin
      doReq(7'h4C, 2'd0, 1'b1, 1'b1, 32'hDEAD_BEE0 | pv);
      for (int a = 0; a < 128; a++)
        for (int c = 0; c < 4; c++)
          for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++) begin
              logic [31:0] d;
              d = {8'hC3 ^ 8'(a), 8'(c * 16 + p * 4 + w), 8'(pv), 8'(a)};
              if (a == 'h4C) d = (d & ~32'd1) | pv;
              doReq(7'(a), 2'(c), 1'(p), 1'(w), d);
            end
      // Read everything back after the write sweep (R6, R7, R10).
      for (int a = 0; a < 128; a += 4) doReq(7'(a), 2'd0, 1'b1, 1'b0, 32'd0);
    end
    doReq(7'h4C, 2'd0, 1'b0, 1'b1, 32'd0);  // R2 with protection on
    doReq(7'h4C, 2'd0, 1'b1, 1'b0, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule